// File: doc/BRIEF.md
# I2C Master SCL Phase and Data Timing Generator

This block paces the clock line of an I2C master. A 32-bit timing word gives a prescaler, an SCL low count, an SCL high count, a data hold delay and a data setup delay. The block divides the kernel clock into a prescaled unit and times the two SCL phases in that unit. Inside each low phase it issues a one-cycle strobe telling the byte sequencer when it may change SDA. After that strobe it keeps SCL low until the setup interval has elapsed. Both bus inputs pass through a two-flop synchronizer and a programmable digital noise filter. Each phase count starts only when the filtered line shows the level the block is driving, so the synchronizer and the filter each add cycles to every phase, and a target that stretches the clock lengthens the high phase.

The sequencer raises `run_i` to start clocking and lowers it to stop. While the block is idle the timing word and filter length pass into its working copy. From the first low phase of a run that copy is frozen. A stall input from the sequencer holds SCL low and freezes every phase counter for as long as it is asserted.

Top module: `i2ct_scl_timer`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `scl_low_o`, `sda_upd_o` and `bit_done_o` are 0.
- R2: The timing word is decoded as prescaler P = bits 31:28, setup count SU = bits 23:20, hold count HD = bits 19:16, high count HI = bits 15:8 and low count LO = bits 7:0. The word and the filter length are taken only while the block is idle. A change during a run has no effect until a run starts from idle.
- R3: With SCL looped back and no stall, the low phase (cycles with `scl_low_o` = 1) lasts exactly 2 + D + max((LO+1)(P+1), HD(P+1) + 1 + (SU+1)(P+1)) cycles, where D is the effective filter length.
- R4: In every low phase `sda_upd_o` pulses once, for one cycle. Counting the first cycle with `scl_low_o` = 1 as index 0, the pulse falls at index 2 + D + HD(P+1) + 1. It never occurs while `scl_low_o` is 0.
- R5: SCL is never released earlier than (SU+1)(P+1) cycles after the first cycle of the `sda_upd_o` pulse, even when the low count has already expired.
- R6: The high phase (cycles with `scl_low_o` = 0 inside a run) lasts 2 + D + (HI+1)(P+1) cycles after the line is seen high. If a target holds SCL low for S cycles after release, the phase lengthens by exactly S.
- R7: While `stall_i` is 1 during the counting part of a low phase, `scl_low_o` stays 1 and the hold, low and setup counts do not advance. A stall of S cycles delays both the release and the `sda_upd_o` pulse by S cycles.
- R8: The effective filter length D is `dnf_i`, saturated at 16. A filtered output changes 2 + D cycles after its raw input changes. A raw pulse shorter than D cycles does not appear at the filtered output. D = 0 leaves only the two-cycle synchronizer.
- R9: A run begins with a low phase on the cycle after `run_i` and `en_i` are seen together while idle. At the end of each high phase, `bit_done_o` pulses for one cycle. If `run_i` is still 1 at that point another low phase follows; otherwise the block goes idle with SCL released.
- R10: When `en_i` is 0, `scl_low_o` is 0 from the next cycle on and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| run_i | input | 1 | Sequencer request to keep the clock running |
| stall_i | input | 1 | Sequencer request to hold SCL low and freeze counts |
| timing_i | input | 32 | Packed timing word (fields in R2) |
| dnf_i | input | 5 | Digital filter length in kernel cycles |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_low_o | output | 1 | 1 = pull SCL low |
| sda_upd_o | output | 1 | One-cycle strobe: the sequencer may change SDA |
| bit_done_o | output | 1 | One-cycle strobe at the end of each high phase |
| scl_f_o | output | 1 | Synchronized and filtered SCL |
| sda_f_o | output | 1 | Synchronized and filtered SDA |

## Verification
Two pairs of functions can act in the same cycle. In the first, the low-count expiry coincides with the setup window still running. The bench provokes this with configurations where the hold plus setup delay exceeds the low count, and the measured low length must then follow the setup term rather than the low count. In the second, a stall is raised while the hold count is still in progress. The bench opens the stall a few cycles into counting and expects both the `sda_upd_o` pulse and the release to move by exactly the stall length.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int PRE_W   = 4;
    localparam int DLY_W   = 4;
    localparam int CNT_W   = 8;
    localparam int DNF_W   = 5;
    localparam int DNF_MAX = 16;
    localparam int HOLD_W  = PRE_W + DLY_W + 1;
    localparam int WORD_W  = 32;

    // field positions inside the packed timing word
    localparam int PRE_LSB = 28;
    localparam int SU_LSB  = 20;
    localparam int HD_LSB  = 16;
    localparam int HI_LSB  = 8;
    localparam int LO_LSB  = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DLY_W-1:0] su;
        logic [DLY_W-1:0] hd;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic [DNF_W-1:0] dnf;
    } tcfg_t;

    function automatic tcfg_t decode_cfg(input logic [WORD_W-1:0] word,
                                         input logic [DNF_W-1:0]  dnf);
        tcfg_t c;
        c.pre = word[PRE_LSB +: PRE_W];
        c.su  = word[SU_LSB  +: DLY_W];
        c.hd  = word[HD_LSB  +: DLY_W];
        c.hi  = word[HI_LSB  +: CNT_W];
        c.lo  = word[LO_LSB  +: CNT_W];
        c.dnf = (dnf > DNF_W'(DNF_MAX)) ? DNF_W'(DNF_MAX) : dnf;
        return c;
    endfunction

endpackage

// File: rtl/i2ct_deglitch.sv
module i2ct_deglitch
    import i2ct_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             raw_i,
    input  logic [DNF_W-1:0] dnf_i,
    output logic             filt_o
);

    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic             held;
        logic [DNF_W-1:0] cnt;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d       = q;
        d.sync1 = raw_i;
        d.sync2 = q.sync1;
        if (dnf_i == '0) begin
            d.held = q.sync2;
            d.cnt  = '0;
        end else if (q.sync2 == q.held) begin
            d.cnt = '0;
        end else if (q.cnt == dnf_i - DNF_W'(1)) begin
            d.held = q.sync2;
            d.cnt  = '0;
        end else begin
            d.cnt = q.cnt + DNF_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{sync1: 1'b1, sync2: 1'b1, held: 1'b1, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign filt_o = (dnf_i == '0) ? q.sync2 : q.held;

    // R8: with a filter active and no disagreement, the accepted level holds
    p_level_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dnf_i != '0) && (q.sync2 == q.held) |=> $stable(q.held));

endmodule

// File: rtl/i2ct_unit_timer.sv
module i2ct_unit_timer
    import i2ct_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [PRE_W-1:0] presc_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             fin_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] units;
        logic             done;
    } tmr_t;

    tmr_t q, d;
    logic at_end;

    assign at_end = (q.pre == presc_i) && (q.units == last_i);

    always_comb begin
        d = q;
        if (clr_i) begin
            d = '0;
        end else if (adv_i && !q.done) begin
            if (q.pre == presc_i) begin
                d.pre = '0;
                if (q.units == last_i) begin
                    d.done = 1'b1;
                end else begin
                    d.units = q.units + CNT_W'(1);
                end
            end else begin
                d.pre = q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // finish is flagged in the last counted cycle so the phase ends on that edge
    assign fin_o = q.done || (adv_i && !clr_i && at_end);

    // R7: without advance or clear the count is frozen
    p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i && !adv_i |=> $stable(q.pre) && $stable(q.units));

endmodule

// File: rtl/i2ct_scl_timer.sv
module i2ct_scl_timer
    import i2ct_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              run_i,
    input  logic              stall_i,
    input  logic [WORD_W-1:0] timing_i,
    input  logic [DNF_W-1:0]  dnf_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_upd_o,
    output logic              bit_done_o,
    output logic              scl_f_o,
    output logic              sda_f_o
);

    localparam int N_LINES  = 2;
    localparam int N_TMR    = 3;
    localparam int T_LOW    = 0;
    localparam int T_HIGH   = 1;
    localparam int T_SETUP  = 2;

    typedef struct packed {
        phase_e            st;
        tcfg_t             cfg;
        logic [HOLD_W-1:0] hcnt;
        logic              seen;
        logic              upd;
        logic              bdone;
    } ctl_t;

    ctl_t q, d;

    logic unused_rsvd;
    assign unused_rsvd = ^timing_i[SU_LSB + DLY_W +: PRE_LSB - SU_LSB - DLY_W];

    // ---------------- input synchronizer and noise filter ----------------
    logic [N_LINES-1:0] raw_w;
    logic [N_LINES-1:0] filt_w;
    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2ct_deglitch u_flt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .raw_i  (raw_w[g]),
            .dnf_i  (q.cfg.dnf),
            .filt_o (filt_w[g])
        );
    end

    assign scl_f_o = filt_w[0];
    assign sda_f_o = filt_w[1];

    // ---------------- phase and setup timers ----------------
    logic             arm_lo;
    logic             arm_hi;
    logic             t_clr  [N_TMR];
    logic             t_adv  [N_TMR];
    logic [CNT_W-1:0] t_last [N_TMR];
    logic             t_fin  [N_TMR];

    always_comb begin
        arm_lo = (q.st == ST_LOW)  && en_i && !stall_i && !scl_f_o;
        arm_hi = (q.st == ST_HIGH) && en_i && scl_f_o;

        t_clr[T_LOW]   = (q.st != ST_LOW);
        t_adv[T_LOW]   = arm_lo;
        t_last[T_LOW]  = q.cfg.lo;

        t_clr[T_HIGH]  = (q.st != ST_HIGH);
        t_adv[T_HIGH]  = arm_hi;
        t_last[T_HIGH] = q.cfg.hi;

        t_clr[T_SETUP]  = (q.st != ST_LOW);
        t_adv[T_SETUP]  = (q.st == ST_LOW) && en_i && !stall_i && q.seen;
        t_last[T_SETUP] = CNT_W'(q.cfg.su);
    end

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        i2ct_unit_timer u_tmr (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (t_clr[t]),
            .adv_i   (t_adv[t]),
            .presc_i (q.cfg.pre),
            .last_i  (t_last[t]),
            .fin_o   (t_fin[t])
        );
    end

    // ---------------- hold delay and phase sequencing ----------------
    logic [HOLD_W-1:0] hold_last;
    logic              hold_hit;

    assign hold_last = HOLD_W'(q.cfg.hd) * (HOLD_W'(q.cfg.pre) + HOLD_W'(1));
    assign hold_hit  = arm_lo && !q.seen && (q.hcnt == hold_last);

    always_comb begin
        d       = q;
        d.upd   = 1'b0;
        d.bdone = 1'b0;

        if (q.st != ST_LOW) begin
            d.hcnt = '0;
            d.seen = 1'b0;
        end else if (arm_lo && !q.seen) begin
            d.hcnt = q.hcnt + HOLD_W'(1);
            if (hold_hit) begin
                d.upd  = 1'b1;
                d.seen = 1'b1;
            end
        end

        unique case (q.st)
            ST_IDLE: begin
                d.cfg = decode_cfg(timing_i, dnf_i);
                if (en_i && run_i) begin
                    d.st = ST_LOW;
                end
            end
            ST_LOW: begin
                if (!en_i) begin
                    d.st = ST_IDLE;
                end else if (t_fin[T_LOW] && t_fin[T_SETUP]) begin
                    d.st = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (!en_i) begin
                    d.st = ST_IDLE;
                end else if (t_fin[T_HIGH]) begin
                    d.bdone = 1'b1;
                    d.st    = run_i ? ST_LOW : ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, cfg: '0, hcnt: '0, seen: 1'b0, upd: 1'b0, bdone: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign scl_low_o  = (q.st == ST_LOW);
    assign sda_upd_o  = q.upd;
    assign bit_done_o = q.bdone;

    // ---------------- assertions ----------------
    p_upd_in_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_upd_o |-> scl_low_o);

    p_setup_before_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(scl_low_o) && $past(en_i) |-> $past(t_fin[T_SETUP]));

    p_stall_holds_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scl_low_o && stall_i && en_i |=> scl_low_o);

    p_cfg_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st != ST_IDLE) |=> $stable(q.cfg));

    p_bit_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_done_o |=> !bit_done_o);

    p_disable_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !scl_low_o);

endmodule

// File: tb/tb_i2ct_scl_timer.sv
module tb_i2ct_scl_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        run = 1'b0;
    logic        stall = 1'b0;
    logic [31:0] timing = '0;
    logic [4:0]  dnf = '0;
    logic        stretch = 1'b0;
    logic        sda_raw = 1'b1;
    logic        scl_pin;
    logic        scl_low, sda_upd, bit_done, scl_f, sda_f;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    assign scl_pin = ~scl_low & ~stretch;

    i2ct_scl_timer dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .run_i      (run),
        .stall_i    (stall),
        .timing_i   (timing),
        .dnf_i      (dnf),
        .scl_i      (scl_pin),
        .sda_i      (sda_raw),
        .scl_low_o  (scl_low),
        .sda_upd_o  (sda_upd),
        .bit_done_o (bit_done),
        .scl_f_o    (scl_f),
        .sda_f_o    (sda_f)
    );

    // columns: prescaler, setup, hold, high, low, filter
    localparam int NV = 5;
    localparam int VEC [NV][6] = '{
        '{0, 0, 0, 3, 4, 0},
        '{1, 2, 1, 2, 3, 1},
        '{3, 1, 2, 1, 1, 2},
        '{2, 0, 0, 5, 7, 0},
        '{0, 3, 4, 0, 0, 3}
    };

    function automatic logic [31:0] pack(int p, int su, int hd, int hi, int lo);
        return {4'(p), 4'h0, 4'(su), 4'(hd), 8'(hi), 8'(lo)};
    endfunction

    function automatic int eff_d(int d);
        return (d > 16) ? 16 : d;
    endfunction

    function automatic int exp_low(int p, int su, int hd, int lo, int d);
        int kl = (lo + 1) * (p + 1);
        int ks = hd * (p + 1) + 1 + (su + 1) * (p + 1);
        return 2 + eff_d(d) + ((kl > ks) ? kl : ks);
    endfunction

    function automatic int exp_hold(int p, int hd, int d);
        return 2 + eff_d(d) + hd * (p + 1) + 1;
    endfunction

    function automatic int exp_high(int p, int hi, int d);
        return 2 + eff_d(d) + (hi + 1) * (p + 1);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // counts a low phase; index 0 is the first cycle with scl_low set
    task automatic measure_low(input int st_at, input int st_len,
                               output int len, output int hidx, output int bd0);
        int cap = 0;
        int idx = 0;
        hidx = -1;
        bd0  = 0;
        while (!scl_low && cap < 5000) begin
            cap++;
            @(negedge clk);
        end
        bd0 = bit_done;
        while (scl_low && idx < 5000) begin
            if (st_len > 0 && idx == st_at) stall = 1'b1;
            if (st_len > 0 && idx == st_at + st_len) stall = 1'b0;
            if (sda_upd && hidx < 0) hidx = idx;
            idx++;
            @(negedge clk);
        end
        stall = 1'b0;
        len = idx;
    endtask

    task automatic measure_high(input int s, output int len);
        int idx = 0;
        while (!scl_low && idx < 5000) begin
            if (s > 0 && idx == 0) stretch = 1'b1;
            if (idx == s) stretch = 1'b0;
            idx++;
            @(negedge clk);
        end
        stretch = 1'b0;
        len = idx;
    endtask

    task automatic finish_run();
        run = 1'b0;
        repeat (400) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int len, hidx, bd, hl, l2, bd2, p, su, hd, hi, lo, d;

        repeat (3) @(negedge clk);
        chk("R1 scl_low in reset", int'(scl_low), 0);
        chk("R1 sda_upd in reset", int'(sda_upd), 0);
        chk("R1 bit_done in reset", int'(bit_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scl_low after reset", int'(scl_low), 0);
        chk("R1 sda_upd after reset", int'(sda_upd), 0);
        en = 1'b1;

        // table walk: R3 low length, R4 hold index, R6 high length, R9 sequencing
        for (int i = 0; i < NV; i++) begin
            p = VEC[i][0]; su = VEC[i][1]; hd = VEC[i][2];
            hi = VEC[i][3]; lo = VEC[i][4]; d = VEC[i][5];
            timing = pack(p, su, hd, hi, lo);
            dnf = 5'(d);
            repeat (3) @(negedge clk);
            run = 1'b1;
            measure_low(0, 0, len, hidx, bd);
            if ((lo + 1) * (p + 1) < hd * (p + 1) + 1 + (su + 1) * (p + 1))
                chk("R5 low length set by setup", len, exp_low(p, su, hd, lo, d));
            else
                chk("R3 low length", len, exp_low(p, su, hd, lo, d));
            chk("R4 hold index", hidx, exp_hold(p, hd, d));
            chk("R9 no bit_done at first low", bd, 0);
            measure_high(0, hl);
            chk("R6 high length", hl, exp_high(p, hi, d));
            measure_low(0, 0, l2, hidx, bd2);
            chk("R9 bit_done opens next low", bd2, 1);
            chk("R3 second low length", l2, exp_low(p, su, hd, lo, d));
            finish_run();
            chk("R9 idle after run drops", int'(scl_low), 0);
        end

        // R6 clock stretching by a target
        timing = pack(0, 0, 0, 3, 4);
        dnf = 5'd0;
        repeat (3) @(negedge clk);
        run = 1'b1;
        measure_low(0, 0, len, hidx, bd);
        measure_high(7, hl);
        chk("R6 stretched high length", hl, 7 + exp_high(0, 3, 0));
        finish_run();

        // R7 stall in the middle of the hold count
        timing = pack(0, 0, 6, 2, 4);
        repeat (3) @(negedge clk);
        run = 1'b1;
        measure_low(3, 10, len, hidx, bd);
        chk("R7 stalled low length", len, exp_low(0, 0, 6, 4, 0) + 10);
        chk("R7 stalled hold index", hidx, exp_hold(0, 6, 0) + 10);
        finish_run();

        // R2 timing word change during a run is ignored
        timing = pack(1, 2, 1, 2, 3);
        dnf = 5'd1;
        repeat (3) @(negedge clk);
        run = 1'b1;
        measure_low(0, 0, len, hidx, bd);
        timing = pack(2, 0, 0, 5, 7);
        dnf = 5'd0;
        measure_high(0, hl);
        chk("R2 high keeps old timing", hl, exp_high(1, 2, 1));
        measure_low(0, 0, len, hidx, bd);
        chk("R2 low keeps old timing", len, exp_low(1, 2, 1, 3, 1));
        finish_run();
        run = 1'b1;
        measure_low(0, 0, len, hidx, bd);
        chk("R2 new timing at next start", len, exp_low(2, 0, 0, 7, 0));
        finish_run();

        // R8 filter length saturation
        timing = pack(0, 0, 0, 3, 4);
        dnf = 5'd31;
        repeat (3) @(negedge clk);
        run = 1'b1;
        measure_low(0, 0, len, hidx, bd);
        chk("R8 saturated filter low length", len, exp_low(0, 0, 0, 4, 16));
        chk("R8 saturated filter hold index", hidx, exp_hold(0, 0, 16));
        finish_run();

        // R8 filter latency and glitch rejection on SDA, filter length 4
        dnf = 5'd4;
        repeat (4) @(negedge clk);
        sda_raw = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 sda not yet filtered through", int'(sda_f), 1);
        @(negedge clk);
        chk("R8 sda filtered after 2+D", int'(sda_f), 0);
        sda_raw = 1'b1;
        repeat (10) @(negedge clk);
        begin
            int lows = 0;
            sda_raw = 1'b0;
            for (int k = 0; k < 12; k++) begin
                if (k == 3) sda_raw = 1'b1;
                @(negedge clk);
                if (!sda_f) lows++;
            end
            chk("R8 short glitch rejected", lows, 0);
        end
        dnf = 5'd0;
        repeat (4) @(negedge clk);
        sda_raw = 1'b0;
        @(negedge clk);
        chk("R8 bypass one cycle in", int'(sda_f), 1);
        @(negedge clk);
        chk("R8 bypass after two cycles", int'(sda_f), 0);
        sda_raw = 1'b1;
        repeat (4) @(negedge clk);

        // R10 enable drop releases SCL
        timing = pack(0, 0, 0, 3, 4);
        repeat (3) @(negedge clk);
        run = 1'b1;
        while (!scl_low) @(negedge clk);
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R10 release after disable", int'(scl_low), 0);
        run = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 stays released", int'(scl_low), 0);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule